// File: doc/BRIEF.md
# Thread-Reserving Cache Replacement Controller

This block makes the replacement decision for a set-associative cache that two hardware threads share. In every set, a fixed group of ways is held back for each thread while that thread is active. A miss by one thread can only evict lines from its own held-back ways or from the common ways. It can never reach the ways held back for the other thread while that thread runs. As a result, neither thread can fill a whole set and push the other one out.

The surrounding cache keeps its tag compare and its data path. On each access it presents the set index, the thread number, the hit result and, on a hit, the way that hit. On a miss the block returns the way to fill in the same cycle. On the next clock edge it marks that way valid and makes it the most recent way of its set. A hit only refreshes the recency of the way that hit.

Ways 0 to RSV-1 are held for thread 0 and ways RSV to 2*RSV-1 for thread 1. The remaining ways are common. With RSV = WAYS/2 every set is split statically between the two threads. With RSV = 0 the block is an ordinary shared LRU.

Top module: `thread_rsv_repl`

## Requirements
- R1: After a synchronous reset every line is invalid and the recency order of each set is way 0 newest through way WAYS-1 oldest. The first miss of thread 0 in any set therefore gets way 0, and the first miss of thread 1 gets way RSV.
- R2: While the other thread's active bit is 1, a miss never selects a way in the other thread's held range. Thread 0's held range is ways 0..RSV-1 and thread 1's is ways RSV..2*RSV-1.
- R3: While a thread's active bit is 0, its held ways are eligible for misses by the other thread, on the same terms as common ways.
- R4: Among the eligible ways, an invalid way is chosen first, and the lowest-numbered invalid way wins.
- R5: If every eligible way is valid, the eligible way that was used least recently is chosen. The recency ranks within each set always form a permutation of 0..WAYS-1.
- R6: The way touched by a hit, or the way filled on a miss, becomes the most recently used way of its set from the next clock edge.
- R7: victim_valid equals acc_valid AND NOT acc_hit in the same cycle, with victim_way valid alongside it. Cycles without an access leave all recency and valid state unchanged.
- R8: A hit selects no victim and does not change which lines are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access present this cycle |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_tid | input | 1 | Thread issuing the access (0 or 1) |
| acc_hit | input | 1 | 1 = the lookup hit |
| acc_hit_way | input | $clog2(WAYS) | Way that hit (used only when acc_hit is 1) |
| thr_active | input | 2 | Bit t = 1 when thread t is active |
| victim_valid | output | 1 | A victim is being returned this cycle |
| victim_way | output | $clog2(WAYS) | Way to fill on the miss |

## Verification
Wrong recency state shows up only on a later miss to the same set, once all eligible ways are valid. That can be many accesses after the fault, so the bench compares every returned victim against its own recency stamps. Wrong valid bits appear sooner, because a line that was wrongly left invalid is picked by the next miss in that set that is allowed to use it. An error in the eligibility mask shows up immediately, as a victim in a held range that the thread may not use.

// File: rtl/trc_pkg.sv
package trc_pkg;

  // flat bit offset of one rank entry in a packed set/way array
  function automatic int rank_offset(int set_i, int way_i, int ways, int rw);
    return (set_i * ways + way_i) * rw;
  endfunction

  // 1 when a way sits in the range held for the thread other than tid
  function automatic bit in_foreign_range(int way_i, bit tid, int rsv);
    if (tid == 1'b0) return (way_i >= rsv) && (way_i < 2 * rsv);
    return way_i < rsv;
  endfunction

endpackage

// File: rtl/trc_cand_mask.sv
module trc_cand_mask #(
  parameter int WAYS = 8,
  parameter int RSV  = 2
) (
  input  logic            tid,
  input  logic [1:0]      active,
  output logic [WAYS-1:0] cand
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    if (w < RSV) begin : g_t0
      assign cand[w] = (tid == 1'b0) | ~active[0];
    end else if (w < 2 * RSV) begin : g_t1
      assign cand[w] = (tid == 1'b1) | ~active[1];
    end else begin : g_shared
      assign cand[w] = 1'b1;
    end
  end
endmodule

// File: rtl/trc_victim_pick.sv
module trc_victim_pick #(
  parameter int WAYS = 8,
  localparam int RW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]    cand,
  input  logic [WAYS-1:0]    vrow,
  input  logic [WAYS*RW-1:0] rrow,
  output logic [RW-1:0]      victim,
  output logic               took_invalid
);
  logic [RW-1:0] inv_way, lru_way, best;
  logic          seen;

  always_comb begin
    took_invalid = 1'b0;
    inv_way      = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (cand[w] && !vrow[w]) begin
        took_invalid = 1'b1;
        inv_way      = RW'(w);
      end
    end
    seen    = 1'b0;
    best    = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (!seen || rrow[w*RW +: RW] > best)) begin
        seen    = 1'b1;
        best    = rrow[w*RW +: RW];
        lru_way = RW'(w);
      end
    end
    victim = took_invalid ? inv_way : lru_way;
  end
endmodule

// File: rtl/trc_state.sv
module trc_state #(
  parameter int WAYS = 8,
  parameter int SETS = 4,
  localparam int RW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_en,
  input  logic                    upd_fill,
  input  logic [SW-1:0]           upd_set,
  input  logic [RW-1:0]           upd_way,
  input  logic [SW-1:0]           rd_set,
  output logic [WAYS-1:0]         vrow,
  output logic [WAYS*RW-1:0]      rrow,
  output logic [SETS*WAYS*RW-1:0] rank_all,
  output logic [SETS*WAYS-1:0]    valid_all
);
  logic [RW-1:0]   rank_q  [SETS][WAYS];
  logic [WAYS-1:0] valid_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RW'(w);
      end
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (RW'(w) == upd_way)
          rank_q[upd_set][w] <= '0;
        else if (rank_q[upd_set][w] < rank_q[upd_set][upd_way])
          rank_q[upd_set][w] <= rank_q[upd_set][w] + 1'b1;
      end
      if (upd_fill) valid_q[upd_set][upd_way] <= 1'b1;
    end
  end

  always_comb begin
    vrow = valid_q[rd_set];
    for (int w = 0; w < WAYS; w++) rrow[w*RW +: RW] = rank_q[rd_set][w];
    for (int s = 0; s < SETS; s++) begin
      valid_all[s*WAYS +: WAYS] = valid_q[s];
      for (int w = 0; w < WAYS; w++)
        rank_all[trc_pkg::rank_offset(s, w, WAYS, RW) +: RW] = rank_q[s][w];
    end
  end
endmodule

// File: rtl/thread_rsv_repl.sv
module thread_rsv_repl #(
  parameter int WAYS = 8,
  parameter int SETS = 4,
  parameter int RSV  = 2,
  localparam int RW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic          acc_tid,
  input  logic          acc_hit,
  input  logic [RW-1:0] acc_hit_way,
  input  logic [1:0]    thr_active,
  output logic          victim_valid,
  output logic [RW-1:0] victim_way
);
  // named internal events for the checker
  logic [WAYS-1:0]         cand_mask;
  logic [WAYS-1:0]         vrow;
  logic [WAYS*RW-1:0]      rrow;
  logic [SETS*WAYS*RW-1:0] rank_all;
  logic [SETS*WAYS-1:0]    valid_all;
  logic [RW-1:0]           pick_way;
  logic                    pick_invalid;
  logic                    upd_en;
  logic                    upd_fill;
  logic [RW-1:0]           upd_way;

  trc_cand_mask #(.WAYS(WAYS), .RSV(RSV)) cand_i (
    .tid(acc_tid), .active(thr_active), .cand(cand_mask)
  );

  trc_victim_pick #(.WAYS(WAYS)) pick_i (
    .cand(cand_mask), .vrow(vrow), .rrow(rrow),
    .victim(pick_way), .took_invalid(pick_invalid)
  );

  assign victim_valid = acc_valid & ~acc_hit;
  assign victim_way   = pick_way;
  assign upd_en       = acc_valid;
  assign upd_fill     = acc_valid & ~acc_hit;
  assign upd_way      = acc_hit ? acc_hit_way : pick_way;

  trc_state #(.WAYS(WAYS), .SETS(SETS)) state_i (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_fill(upd_fill),
    .upd_set(acc_set), .upd_way(upd_way), .rd_set(acc_set),
    .vrow(vrow), .rrow(rrow), .rank_all(rank_all), .valid_all(valid_all)
  );
endmodule

// File: rtl/thread_rsv_repl_chk.sv
module thread_rsv_repl_chk #(
  parameter int WAYS = 8,
  parameter int SETS = 4,
  parameter int RSV  = 2,
  localparam int RW  = $clog2(WAYS),
  localparam int SW  = $clog2(SETS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    acc_valid,
  input logic [SW-1:0]           acc_set,
  input logic                    acc_tid,
  input logic                    acc_hit,
  input logic [1:0]              thr_active,
  input logic                    victim_valid,
  input logic [RW-1:0]           victim_way,
  input logic [WAYS-1:0]         vrow,
  input logic [SETS*WAYS*RW-1:0] rank_all,
  input logic [SETS*WAYS-1:0]    valid_all,
  input logic                    upd_en,
  input logic [RW-1:0]           upd_way
);
  function automatic logic [WAYS-1:0] fold_ranks(logic [SETS*WAYS*RW-1:0] all, int s);
    logic [WAYS-1:0] seen = '0;
    for (int w = 0; w < WAYS; w++)
      seen[all[trc_pkg::rank_offset(s, w, WAYS, RW) +: RW]] = 1'b1;
    return seen;
  endfunction

  function automatic logic [RW-1:0] rank_at(logic [SETS*WAYS*RW-1:0] all, logic [SW-1:0] s,
                                           logic [RW-1:0] w);
    return all[trc_pkg::rank_offset(int'(s), int'(w), WAYS, RW) +: RW];
  endfunction

  logic foreign_hit;
  assign foreign_hit = trc_pkg::in_foreign_range(int'(victim_way), acc_tid, RSV);

  p_no_foreign_r2: assert property (@(posedge clk) disable iff (rst)
    victim_valid && thr_active[~acc_tid] |-> !foreign_hit);

  p_invalid_first_r4: assert property (@(posedge clk) disable iff (rst)
    victim_valid && (thr_active == 2'b11) && !(&vrow) && !(&(vrow | ~({WAYS{1'b1}})))
      && !vrow[0] && (RSV == 0 || acc_tid == 1'b0) |-> !vrow[victim_way]);

  p_mru_r6: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> rank_at(rank_all, $past(acc_set), $past(upd_way)) == '0);

  p_fill_valid_r6: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> valid_all[int'($past(acc_set)) * WAYS + int'($past(victim_way))]);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(rank_all) && $stable(valid_all));

  p_hit_keeps_valid_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_hit |=> $stable(valid_all));

  for (genvar s = 0; s < SETS; s++) begin : g_perm
    p_rank_perm_r5: assert property (@(posedge clk) disable iff (rst)
      &fold_ranks(rank_all, s));
  end
endmodule

bind thread_rsv_repl thread_rsv_repl_chk #(.WAYS(WAYS), .SETS(SETS), .RSV(RSV)) chk_i (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tid(acc_tid),
  .acc_hit(acc_hit), .thr_active(thr_active), .victim_valid(victim_valid),
  .victim_way(victim_way), .vrow(vrow), .rank_all(rank_all), .valid_all(valid_all),
  .upd_en(upd_en), .upd_way(upd_way)
);

// File: tb/thread_rsv_repl_tb_top.sv
module thread_rsv_repl_tb_top;
  localparam int WAYS = 8;
  localparam int SETS = 4;
  localparam int RSV  = 2;
  localparam int RW   = $clog2(WAYS);
  localparam int SW   = $clog2(SETS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic          acc_tid = 1'b0;
  logic          acc_hit = 1'b0;
  logic [RW-1:0] acc_hit_way = '0;
  logic [1:0]    thr_active = 2'b11;
  logic          victim_valid;
  logic [RW-1:0] victim_way;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model: valid flags and recency stamps (larger stamp = newer)
  bit m_valid [SETS][WAYS];
  int m_stamp [SETS][WAYS];
  int m_clock = 1;

  always #5 clk = ~clk;

  thread_rsv_repl #(.WAYS(WAYS), .SETS(SETS), .RSV(RSV)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set), .acc_tid(acc_tid),
    .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .thr_active(thr_active),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  function automatic bit allowed(int w, bit tid, bit [1:0] act);
    int owner;
    if (w < RSV) owner = 0;
    else if (w < 2 * RSV) owner = 1;
    else return 1;
    return (owner == int'(tid)) || !act[owner];
  endfunction

  function automatic int expect_victim(int s, bit tid, bit [1:0] act);
    int pick = -1;
    int oldest = 0;
    for (int w = 0; w < WAYS; w++)
      if (allowed(w, tid, act) && !m_valid[s][w]) return w;
    for (int w = 0; w < WAYS; w++)
      if (allowed(w, tid, act) && (pick < 0 || m_stamp[s][w] < oldest)) begin
        pick = w;
        oldest = m_stamp[s][w];
      end
    return pick;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0;
        m_stamp[s][w] = -w;
      end
  endtask

  task automatic check(bit ok, string req, int act_v, int exp_v);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // one access: drive after negedge, compare, then let the edge update state
  task automatic access(int s, bit tid, bit hit, int hway, bit [1:0] act, string req);
    int ev;
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(s); acc_tid = tid; acc_hit = hit;
    acc_hit_way = RW'(hway); thr_active = act;
    #1;
    check(victim_valid == !hit, {req, " R7 victim_valid"}, int'(victim_valid), int'(!hit));
    if (!hit) begin
      ev = expect_victim(s, tid, act);
      check(int'(victim_way) == ev, req, int'(victim_way), ev);
      if (act[~tid])
        check(!((tid == 0) ? (victim_way >= RSV && victim_way < 2*RSV) : (victim_way < RSV)),
              "R2 foreign range", int'(victim_way), ev);
      m_valid[s][ev] = 1;
      m_stamp[s][ev] = m_clock++;
    end else begin
      m_stamp[s][hway] = m_clock++;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    check(victim_valid == 1'b0, "R7 idle no victim", int'(victim_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int s, hw, nv;
    bit tid, hit;
    bit [1:0] act;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed through the first misses
    idle();
    access(0, 0, 0, 0, 2'b11, "R1 first t0 miss");
    access(0, 1, 0, 0, 2'b11, "R1 first t1 miss");
    // R4 / R5: fill set 1 with thread 0, then wrap to least recent
    for (int i = 0; i < 6; i++) access(1, 0, 0, 0, 2'b11, "R4 lowest invalid");
    access(1, 0, 0, 0, 2'b11, "R5 lru after full");
    // R6 / R8: hit way 1 makes it newest, so the next miss skips it
    access(1, 0, 1, 1, 2'b11, "R8 hit");
    access(1, 0, 0, 0, 2'b11, "R6 hit became mru");
    // R7: idle cycles change nothing
    idle(); idle();
    access(1, 0, 0, 0, 2'b11, "R7 state held");
    // R3: thread 1 inactive, thread 0 reaches ways RSV..2*RSV-1
    for (int i = 0; i < 4; i++) access(2, 0, 0, 0, 2'b01, "R3 inactive gate");
    // R2: thread 1 hammers set 3 while thread 0 active
    for (int i = 0; i < 12; i++) access(3, 1, 0, 0, 2'b11, "R2 no foreign");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      s   = int'($urandom_range(SETS - 1));
      tid = 1'($urandom_range(1));
      act = ($urandom_range(9) < 7) ? 2'b11 : 2'($urandom_range(3));
      hit = ($urandom_range(2) == 0);
      nv  = 0;
      for (int w = 0; w < WAYS; w++) if (m_valid[s][w]) nv++;
      hw = 0;
      if (hit && nv > 0) begin
        int k = int'($urandom_range(nv - 1));
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w]) begin
          if (k == 0) hw = w;
          k--;
        end
      end else hit = 0;
      if ($urandom_range(7) == 0) idle();
      else access(s, tid, hit, hw, act, hit ? "R6 random hit" : "R5 random miss");
    end
    @(negedge clk);
    acc_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule